// File: doc/BRIEF.md
# Shifting ALU with Condition Flags

This block is the data-processing execute stage of a 32-bit integer core. Each cycle in which `in_valid` is high, it takes a first operand straight from the register read port and a second operand that first passes through a barrel shifter. It then forms an arithmetic or bitwise result and works out the negative, zero, carry and overflow flags that would follow from it. The incoming carry flag has two uses. The add-with-carry and subtract-with-carry operations consume it, and the shifter passes it through when the shift amount is zero. The shifter also produces a carry of its own, and the bitwise operations report that carry.

Results and flags are registered, so they appear one clock after the inputs are sampled. Two registered enables come with them and tell the surrounding pipeline what to commit. `res_we` means the result goes to the destination register. `flags_we` means the four flag outputs go to the status register. Compare and test operations raise only `flags_we`. Other operations raise it only when the instruction asks for flags to be set.

Top module: `alu_shift_flags`

## Requirements
- R1: Opcode 0xB (move) returns the shifted second operand. Opcode 0xD (move-not) returns the bitwise inverse of the shifted second operand.
- R2: Opcode 0x4 (add) returns A+B. Opcode 0x5 (add-with-carry) returns A+B+carry_in. Opcode 0x9 (compare-negative) forms A+B. For all three, C is the unsigned carry out of bit 31.
- R3: Opcode 0x2 (subtract) returns A-B. Opcode 0x6 (subtract-with-carry) returns A-B-NOT(carry_in). Opcode 0x3 (reverse subtract) returns B-A, so a zero B negates A. Opcode 0x8 (compare) forms A-B. For all four, C is set when no borrow occurs.
- R4: For the arithmetic opcodes 0x2, 0x3, 0x4, 0x5, 0x6, 0x8 and 0x9, V is set exactly when the result overflows as a signed 32-bit value.
- R5: The bitwise opcodes return: 0x0 A AND B, 0xA A OR B, 0x1 A XOR B, 0xC A AND NOT B. Opcode 0x7 (test) forms A AND B for the flags only.
- R6: N equals bit 31 of the formed value. Z is set when all 32 bits of the formed value are zero.
- R7: For opcodes 0x0, 0x1, 0x7, 0xA, 0xB, 0xC and 0xD, C takes the shifter carry-out and V keeps the value of `v_in`.
- R8: Shift kind 0 is a logical left shift by n, with carry out from operand bit [32-n]. Shift kind 1 is a logical right shift by n, with carry out from bit [n-1].
- R9: Shift kind 2 is an arithmetic right shift, filling with bit 31, with carry out from bit [n-1]. Shift kind 3 is a rotate right, with carry out from bit [n-1].
- R10: A shift amount of zero leaves the second operand unchanged and passes `carry_in` through as the shifter carry, for every shift kind.
- R11: Compare and test opcodes (0x7, 0x8, 0x9) raise `flags_we` and never `res_we`, whatever `set_flags` is.
- R12: Every other defined opcode raises `res_we`. It raises `flags_we` only when `set_flags` is high. The undefined opcodes 0xE and 0xF raise neither enable.
- R13: Outputs appear one clock after the sampled inputs. In a cycle after `in_valid` was low, both enables are low and the result and flag outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs hold an operation this cycle |
| op_code | input | 4 | Operation select |
| set_flags | input | 1 | Instruction requests a flag update |
| opnd_a | input | 32 | First operand, not shifted |
| opnd_b | input | 32 | Second operand, fed through the shifter |
| shift_kind | input | 2 | 0 left, 1 logical right, 2 arithmetic right, 3 rotate right |
| shift_amt | input | 5 | Shift distance 0 to 31 |
| carry_in | input | 1 | Current C flag |
| v_in | input | 1 | Current V flag |
| res_out | output | 32 | Registered result |
| res_we | output | 1 | Result should be written back |
| n_out | output | 1 | Next N flag |
| z_out | output | 1 | Next Z flag |
| c_out | output | 1 | Next C flag |
| v_out | output | 1 | Next V flag |
| flags_we | output | 1 | Flags should be committed |

## Verification
The bench targets the carry conventions, because each one has a plausible wrong version:
- A design that treats the subtract carry as a borrow gives an inverted C on every subtract and compare.
- A design that adds `carry_in` instead of subtracting its inverse gives subtract-with-carry results that are off by one.
- A shifter that drops the incoming carry on a zero amount clears C on plain moves.
- A shifter that takes the left-shift carry from the wrong end reports the wrong bit once n exceeds one.

Further directed cases cover:
- signed overflow in both directions, where a missing operand-inversion term in V shows up;
- negation by reverse subtract from zero;
- compare operations that must not write a result;
- undefined opcodes and idle cycles, where the enables must stay low and the outputs must hold.

// File: rtl/alu_sf_pkg.sv
package alu_sf_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0,
    OP_EOR = 4'h1,
    OP_SUB = 4'h2,
    OP_RSB = 4'h3,
    OP_ADD = 4'h4,
    OP_ADC = 4'h5,
    OP_SBC = 4'h6,
    OP_TST = 4'h7,
    OP_CMP = 4'h8,
    OP_CMN = 4'h9,
    OP_ORR = 4'hA,
    OP_MOV = 4'hB,
    OP_BIC = 4'hC,
    OP_MVN = 4'hD
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_e;

  typedef enum logic [2:0] {
    AS_ADD,
    AS_ADC,
    AS_SUB,
    AS_SBC,
    AS_RSB
  } addsub_e;

  typedef enum logic [2:0] {
    LG_AND,
    LG_ORR,
    LG_EOR,
    LG_BIC,
    LG_MOV,
    LG_MVN
  } logic_e;

  typedef struct packed {
    logic    known;
    logic    use_adder;
    logic    flag_only;
    addsub_e as_sel;
    logic_e  lg_sel;
  } op_ctrl_t;

endpackage

// File: rtl/alu_sf_rst_sync.sv
module alu_sf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/alu_sf_decode.sv
module alu_sf_decode
  import alu_sf_pkg::*;
(
  input  logic [3:0] op_code,
  output op_ctrl_t   ctrl
);

  always_comb begin
    ctrl           = '0;
    ctrl.as_sel    = AS_ADD;
    ctrl.lg_sel    = LG_AND;
    ctrl.known     = 1'b1;
    unique case (op_code)
      OP_ADD: begin ctrl.use_adder = 1'b1; ctrl.as_sel = AS_ADD; end
      OP_ADC: begin ctrl.use_adder = 1'b1; ctrl.as_sel = AS_ADC; end
      OP_SUB: begin ctrl.use_adder = 1'b1; ctrl.as_sel = AS_SUB; end
      OP_SBC: begin ctrl.use_adder = 1'b1; ctrl.as_sel = AS_SBC; end
      OP_RSB: begin ctrl.use_adder = 1'b1; ctrl.as_sel = AS_RSB; end
      OP_CMP: begin
        ctrl.use_adder = 1'b1;
        ctrl.as_sel    = AS_SUB;
        ctrl.flag_only = 1'b1;
      end
      OP_CMN: begin
        ctrl.use_adder = 1'b1;
        ctrl.as_sel    = AS_ADD;
        ctrl.flag_only = 1'b1;
      end
      OP_TST: begin
        ctrl.lg_sel    = LG_AND;
        ctrl.flag_only = 1'b1;
      end
      OP_AND: ctrl.lg_sel = LG_AND;
      OP_ORR: ctrl.lg_sel = LG_ORR;
      OP_EOR: ctrl.lg_sel = LG_EOR;
      OP_BIC: ctrl.lg_sel = LG_BIC;
      OP_MOV: ctrl.lg_sel = LG_MOV;
      OP_MVN: ctrl.lg_sel = LG_MVN;
      default: ctrl.known = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_sf_shifter.sv
module alu_sf_shifter
  import alu_sf_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] amt,
  input  logic          cin,
  output logic [W-1:0]  dout,
  output logic          cout
);

  // One stage per amount bit; each stage shifts by a power of two and
  // records the last bit it pushed out, so the final carry is the last
  // bit shifted out overall.
  logic [AW:0][W-1:0] stg;
  logic [AW:0]        cy;

  assign stg[0] = din;
  assign cy[0]  = cin;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int unsigned K = 1 << s;
    logic [W-1:0] nxt;
    logic         ncy;

    always_comb begin
      nxt = stg[s];
      ncy = cy[s];
      if (amt[s]) begin
        unique case (shift_e'(kind))
          SH_LSL: begin
            nxt = stg[s] << K;
            ncy = stg[s][W-K];
          end
          SH_LSR: begin
            nxt = stg[s] >> K;
            ncy = stg[s][K-1];
          end
          SH_ASR: begin
            nxt = W'($signed(stg[s]) >>> K);
            ncy = stg[s][K-1];
          end
          default: begin
            nxt = {stg[s][K-1:0], stg[s][W-1:K]};
            ncy = stg[s][K-1];
          end
        endcase
      end
    end

    assign stg[s+1] = nxt;
    assign cy[s+1]  = ncy;
  end

  assign dout = stg[AW];
  assign cout = cy[AW];

endmodule

// File: rtl/alu_sf_addsub.sv
module alu_sf_addsub
  import alu_sf_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  addsub_e      sel,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);

  logic [W-1:0] x_op;
  logic [W-1:0] y_op;
  logic         c_op;

  // Subtraction is x + ~y + carry; C out then means "no borrow".
  always_comb begin
    unique case (sel)
      AS_ADC:  begin x_op = a; y_op = b;  c_op = cin;  end
      AS_SUB:  begin x_op = a; y_op = ~b; c_op = 1'b1; end
      AS_SBC:  begin x_op = a; y_op = ~b; c_op = cin;  end
      AS_RSB:  begin x_op = b; y_op = ~a; c_op = 1'b1; end
      default: begin x_op = a; y_op = b;  c_op = 1'b0; end
    endcase
  end

  assign {cout, sum} = {1'b0, x_op} + {1'b0, y_op} + {{W{1'b0}}, c_op};
  assign ovf = (x_op[W-1] ~^ y_op[W-1]) & (sum[W-1] ^ x_op[W-1]);

endmodule

// File: rtl/alu_sf_logic.sv
module alu_sf_logic
  import alu_sf_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_e       sel,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (sel)
      LG_ORR:  y = a | b;
      LG_EOR:  y = a ^ b;
      LG_BIC:  y = a & ~b;
      LG_MOV:  y = b;
      LG_MVN:  y = ~b;
      default: y = a & b;
    endcase
  end

endmodule

// File: rtl/alu_shift_flags.sv
module alu_shift_flags
  import alu_sf_pkg::*;
#(
  parameter  int unsigned DATA_W = 32,
  localparam int unsigned AMT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op_code,
  input  logic              set_flags,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [1:0]        shift_kind,
  input  logic [AMT_W-1:0]  shift_amt,
  input  logic              carry_in,
  input  logic              v_in,
  output logic [DATA_W-1:0] res_out,
  output logic              res_we,
  output logic              n_out,
  output logic              z_out,
  output logic              c_out,
  output logic              v_out,
  output logic              flags_we
);

  logic rst_n_i;

  alu_sf_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  op_ctrl_t ctrl;

  alu_sf_decode u_dec (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  logic [DATA_W-1:0] sh_val;
  logic              sh_c;

  alu_sf_shifter #(.W(DATA_W), .AW(AMT_W)) u_shift (
    .din  (opnd_b),
    .kind (shift_kind),
    .amt  (shift_amt),
    .cin  (carry_in),
    .dout (sh_val),
    .cout (sh_c)
  );

  logic [DATA_W-1:0] as_sum;
  logic              as_c;
  logic              as_v;

  alu_sf_addsub #(.W(DATA_W)) u_addsub (
    .a    (opnd_a),
    .b    (sh_val),
    .cin  (carry_in),
    .sel  (ctrl.as_sel),
    .sum  (as_sum),
    .cout (as_c),
    .ovf  (as_v)
  );

  logic [DATA_W-1:0] lg_val;

  alu_sf_logic #(.W(DATA_W)) u_logic (
    .a   (opnd_a),
    .b   (sh_val),
    .sel (ctrl.lg_sel),
    .y   (lg_val)
  );

  // next-state
  logic [DATA_W-1:0] res_d;
  logic              n_d, z_d, c_d, v_d, rwe_d, fwe_d;

  always_comb begin
    res_d = ctrl.use_adder ? as_sum : lg_val;
    c_d   = ctrl.use_adder ? as_c   : sh_c;
    v_d   = ctrl.use_adder ? as_v   : v_in;
    n_d   = res_d[DATA_W-1];
    z_d   = ~|res_d;
    rwe_d = in_valid & ctrl.known & ~ctrl.flag_only;
    fwe_d = in_valid & ctrl.known & (set_flags | ctrl.flag_only);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      res_out  <= '0;
      n_out    <= 1'b0;
      z_out    <= 1'b0;
      c_out    <= 1'b0;
      v_out    <= 1'b0;
      res_we   <= 1'b0;
      flags_we <= 1'b0;
    end else begin
      res_we   <= rwe_d;
      flags_we <= fwe_d;
      if (in_valid) begin
        res_out <= res_d;
        n_out   <= n_d;
        z_out   <= z_d;
        c_out   <= c_d;
        v_out   <= v_d;
      end
    end
  end

  // assertions
  a_r11_flag_only: assert property (@(posedge clk) disable iff (!rst_n_i)
    (in_valid && (op_code == OP_CMP || op_code == OP_CMN || op_code == OP_TST))
    |=> (flags_we && !res_we));

  a_r12_no_set: assert property (@(posedge clk) disable iff (!rst_n_i)
    (in_valid && !set_flags && op_code != OP_CMP && op_code != OP_CMN
     && op_code != OP_TST) |=> !flags_we);

  a_r13_idle_hold: assert property (@(posedge clk) disable iff (!rst_n_i)
    !in_valid |=> (!res_we && !flags_we && $stable(res_out)
                   && $stable(c_out) && $stable(v_out)));

  a_r6_nz: assert property (@(posedge clk) disable iff (!rst_n_i)
    (res_we && flags_we) |-> (n_out == res_out[DATA_W-1]
                              && z_out == (res_out == '0)));

  a_r7_v_keep: assert property (@(posedge clk) disable iff (!rst_n_i)
    (in_valid && (op_code == OP_MOV || op_code == OP_AND || op_code == OP_EOR))
    |=> (v_out == $past(v_in)));

  a_r10_zero_pass: assert property (@(posedge clk) disable iff (!rst_n_i)
    (in_valid && op_code == OP_MOV && shift_amt == '0)
    |=> (res_out == $past(opnd_b) && c_out == $past(carry_in)));

  a_r2_add_carry: assert property (@(posedge clk) disable iff (!rst_n_i)
    (in_valid && op_code == OP_ADD && shift_amt == '0)
    |=> (c_out == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)} > {1'b0, {DATA_W{1'b1}}})));

endmodule

// File: tb/tb_alu_shift_flags.sv
module tb_alu_shift_flags;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op_code;
  logic        set_flags;
  logic [31:0] opnd_a, opnd_b;
  logic [1:0]  shift_kind;
  logic [4:0]  shift_amt;
  logic        carry_in, v_in;
  logic [31:0] res_out;
  logic        res_we, n_out, z_out, c_out, v_out, flags_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  alu_shift_flags dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .set_flags(set_flags), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .shift_kind(shift_kind), .shift_amt(shift_amt), .carry_in(carry_in),
    .v_in(v_in), .res_out(res_out), .res_we(res_we), .n_out(n_out),
    .z_out(z_out), .c_out(c_out), .v_out(v_out), .flags_we(flags_we)
  );

  // Model: returns {rwe, fwe, n, z, c, v, res}
  function automatic logic [37:0] model(input logic [3:0] op, input logic sf,
      input logic [31:0] a, input logic [31:0] b, input logic [1:0] k,
      input logic [4:0] n, input logic c, input logic v);
    logic [63:0] t;
    logic [31:0] sb, r;
    logic        sc, rc, rv, known, fonly, arith;
    longint      ud, sd;
    t = '0;
    sb = b; sc = c;
    if (n != 0) begin
      case (k)
        2'd0: begin t = {32'b0, b} << n; sb = t[31:0];  sc = t[32]; end
        2'd1: begin t = {b, 32'b0} >> n; sb = t[63:32]; sc = t[31]; end
        2'd2: begin t = $signed({b, 32'b0}) >>> n; sb = t[63:32]; sc = t[31]; end
        default: begin t = {b, b} >> n; sb = t[31:0]; sc = sb[31]; end
      endcase
    end
    known = (op <= 4'hD);
    fonly = (op == 4'h7 || op == 4'h8 || op == 4'h9);
    arith = (op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9});
    r = '0; rc = sc; rv = v;
    ud = 0; sd = 0;
    case (op)
      4'h4, 4'h9, 4'h5: begin
        ud = longint'(a) + longint'(sb) + ((op == 4'h5 && c) ? 1 : 0);
        sd = longint'($signed(a)) + longint'($signed(sb)) + ((op == 4'h5 && c) ? 1 : 0);
        rc = (ud > 64'hFFFF_FFFF);
      end
      4'h2, 4'h8, 4'h6: begin
        ud = longint'(a) - longint'(sb) - ((op == 4'h6 && !c) ? 1 : 0);
        sd = longint'($signed(a)) - longint'($signed(sb)) - ((op == 4'h6 && !c) ? 1 : 0);
        rc = (ud >= 0);
      end
      4'h3: begin
        ud = longint'(sb) - longint'(a);
        sd = longint'($signed(sb)) - longint'($signed(a));
        rc = (ud >= 0);
      end
      4'h0, 4'h7: r = a & sb;
      4'hA: r = a | sb;
      4'h1: r = a ^ sb;
      4'hC: r = a & ~sb;
      4'hB: r = sb;
      4'hD: r = ~sb;
      default: r = '0;
    endcase
    if (arith) begin
      r  = ud[31:0];
      rv = (sd > 64'sd2147483647) || (sd < -64'sd2147483648);
    end
    return {known && !fonly, known && (sf || fonly), r[31], (r == 0), rc, rv, r};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'hB, 4'hD: return "R1";
      4'h4, 4'h5, 4'h9: return "R2";
      4'h2, 4'h3, 4'h6, 4'h8: return "R3";
      4'h0, 4'h1, 4'h7, 4'hA, 4'hC: return "R5";
      default: return "R12";
    endcase
  endfunction

  task automatic run_op(input string tag, input logic [3:0] op, input logic sf,
      input logic [31:0] a, input logic [31:0] b, input logic [1:0] k,
      input logic [4:0] n, input logic c, input logic v);
    logic [37:0] e;
    bit bad;
    e = model(op, sf, a, b, k, n, c, v);
    @(negedge clk);
    in_valid = 1'b1; op_code = op; set_flags = sf; opnd_a = a; opnd_b = b;
    shift_kind = k; shift_amt = n; carry_in = c; v_in = v;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    bad = (res_we !== e[37]) || (flags_we !== e[36]);
    if (e[37] && res_out !== e[31:0]) bad = 1;
    if (e[36] && {n_out, z_out, c_out, v_out} !== e[35:32]) bad = 1;
    if (bad) begin
      fails++;
      $display("FAIL %s op=%h k=%0d n=%0d: got res=%h we=%b fwe=%b nzcv=%b%b%b%b exp res=%h we=%b fwe=%b nzcv=%b",
               tag, op, k, n, res_out, res_we, flags_we, n_out, z_out, c_out, v_out,
               e[31:0], e[37], e[36], e[35:32]);
    end
  endtask

  task automatic hold_check();
    logic [31:0] pr;
    logic [3:0]  pf;
    pr = res_out; pf = {n_out, z_out, c_out, v_out};
    @(negedge clk);
    in_valid = 1'b0; op_code = 4'h4; opnd_a = $urandom; opnd_b = $urandom;
    set_flags = 1'b1; carry_in = ~carry_in; v_in = ~v_in;
    @(negedge clk);
    checks++;
    if (res_we !== 1'b0 || flags_we !== 1'b0 || res_out !== pr ||
        {n_out, z_out, c_out, v_out} !== pf) begin
      fails++;
      $display("FAIL R13 idle: got res=%h we=%b fwe=%b nzcv=%b%b%b%b exp res=%h we=0 fwe=0 nzcv=%b",
               res_out, res_we, flags_we, n_out, z_out, c_out, v_out, pr, pf);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; op_code = 4'h0; set_flags = 1'b0;
    opnd_a = '0; opnd_b = '0; shift_kind = 2'd0; shift_amt = '0;
    carry_in = 1'b0; v_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state, R13
    checks++;
    if (res_out !== '0 || res_we !== 1'b0 || flags_we !== 1'b0) begin
      fails++;
      $display("FAIL R13 reset: got res=%h we=%b fwe=%b exp res=0 we=0 fwe=0",
               res_out, res_we, flags_we);
    end

    // R1 move / move-not
    run_op("R1", 4'hB, 1, 32'h1234_5678, 32'h0000_00F0, 2'd0, 5'd4, 0, 1);
    run_op("R1", 4'hD, 1, 32'h0, 32'h0F0F_0000, 2'd1, 5'd8, 1, 0);
    // R2 add / adc / cmn carries
    run_op("R2", 4'h4, 1, 32'hFFFF_FFFF, 32'h1, 2'd0, 5'd0, 0, 0);
    run_op("R2", 4'h5, 1, 32'h10, 32'h20, 2'd0, 5'd0, 1, 0);
    run_op("R2", 4'h9, 0, 32'h8000_0000, 32'h8000_0000, 2'd0, 5'd0, 0, 0);
    // R3 sub / sbc / rsb negate / cmp
    run_op("R3", 4'h2, 1, 32'h5, 32'h7, 2'd0, 5'd0, 1, 0);
    run_op("R3", 4'h6, 1, 32'h10, 32'h3, 2'd0, 5'd0, 0, 0);
    run_op("R3", 4'h6, 1, 32'h10, 32'h3, 2'd0, 5'd0, 1, 0);
    run_op("R3", 4'h3, 1, 32'h0000_0009, 32'h0, 2'd0, 5'd0, 0, 0);
    run_op("R3", 4'h8, 0, 32'h42, 32'h42, 2'd0, 5'd0, 0, 1);
    // R4 signed overflow both ways
    run_op("R4", 4'h4, 1, 32'h7FFF_FFFF, 32'h1, 2'd0, 5'd0, 0, 0);
    run_op("R4", 4'h2, 1, 32'h8000_0000, 32'h1, 2'd0, 5'd0, 0, 0);
    run_op("R4", 4'h2, 1, 32'h1, 32'h8000_0000, 2'd0, 5'd0, 0, 0);
    // R5 bitwise, BIC
    run_op("R5", 4'hC, 1, 32'hFFFF_00FF, 32'h0F0F_0F0F, 2'd0, 5'd0, 0, 0);
    run_op("R5", 4'h7, 0, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 2'd0, 5'd0, 1, 1);
    // R6 zero and negative
    run_op("R6", 4'h1, 1, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 2'd0, 5'd0, 0, 0);
    run_op("R6", 4'hA, 1, 32'h8000_0000, 32'h1, 2'd0, 5'd0, 0, 0);
    // R7 logical C from shifter, V kept
    run_op("R7", 4'h0, 1, 32'hFFFF_FFFF, 32'h8000_0001, 2'd0, 5'd1, 0, 1);
    // R8 LSL / LSR carries
    run_op("R8", 4'hB, 1, 32'h0, 32'h1000_0000, 2'd0, 5'd4, 0, 0);
    run_op("R8", 4'hB, 1, 32'h0, 32'h0000_0010, 2'd1, 5'd5, 0, 0);
    run_op("R8", 4'hB, 1, 32'h0, 32'h8000_0000, 2'd0, 5'd1, 0, 0);
    // R9 ASR / ROR
    run_op("R9", 4'hB, 1, 32'h0, 32'h8000_0040, 2'd2, 5'd7, 0, 0);
    run_op("R9", 4'hB, 1, 32'h0, 32'h0000_0081, 2'd3, 5'd1, 0, 0);
    run_op("R9", 4'hB, 1, 32'h0, 32'h1234_5678, 2'd3, 5'd31, 0, 0);
    // R10 zero amount passes operand and carry, each kind
    for (int kk = 0; kk < 4; kk++) begin
      run_op("R10", 4'hB, 1, 32'h0, 32'hDEAD_BEEF, 2'(kk), 5'd0, 1, 0);
    end
    // R11 compare without set_flags still updates flags only
    run_op("R11", 4'h9, 0, 32'h1, 32'h2, 2'd0, 5'd0, 0, 0);
    // R12 no set_flags, undefined opcodes
    run_op("R12", 4'h4, 0, 32'h1, 32'h2, 2'd0, 5'd0, 0, 0);
    run_op("R12", 4'hE, 1, 32'h1, 32'h2, 2'd0, 5'd0, 0, 0);
    run_op("R12", 4'hF, 1, 32'h1, 32'h2, 2'd0, 5'd0, 0, 0);
    // R13 idle hold
    run_op("R13", 4'h2, 1, 32'h3, 32'h9, 2'd0, 5'd0, 1, 0);
    hold_check();

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  rop;
      logic [4:0]  ramt;
      logic [31:0] ra, rb;
      rop  = 4'($urandom_range(0, 15));
      ramt = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
      ra   = ($urandom_range(0, 7) == 0) ? 32'h7FFF_FFFF : $urandom;
      rb   = ($urandom_range(0, 7) == 0) ? 32'h8000_0000 : $urandom;
      run_op(tag_of(rop), rop, 1'($urandom), ra, rb, 2'($urandom), ramt,
             1'($urandom), 1'($urandom));
      if (i % 50 == 0) hold_check();
    end

    finish_run();
  end

endmodule